// File: doc/BRIEF.md
# Bus Wake-Up Detector

This block runs while a bus node sits in its deepest low-power state. It watches the level of a single-wire bus and two local wake sources: an active-low wake pin and a chip-select line. When one of them shows a valid wake condition, the block sends a one-cycle wake request to the mode controller. The mode controller enables detection with `arm_en` only while the node is powered down. Outside that state the request output stays low.

Bus wake-up has two variants, chosen by `variant_sel`. With `variant_sel = 0`, a high-to-low bus transition followed by a dominant level that lasts for the level debounce count raises the request while the bus is still low. With `variant_sel = 1`, a low that lasts for the longer debounce count only arms the detector, and the request is raised on the following return to the recessive (high) level. The second variant stops a floating bus that drifts low from waking the node, because a drifting bus never returns high on its own.

All three asynchronous inputs pass through a two-flop synchronizer. Chip select also passes through a glitch filter whose length is a cycle-count parameter. After the block raises a request it goes quiet and stays quiet until the mode controller drops `arm_en` and raises it again.

Top module: `bus_wake_detector`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any cycle with `arm_en` low, `wake_req` is 0. No bus, wake-pin or chip-select activity while disarmed produces a request.
- R2: Every request is exactly one clock cycle wide.
- R3: With `variant_sel = 0`, a high-to-low bus transition followed by at least `DEB_A_CYC` consecutive low samples raises a request. The request comes while the bus is still low.
- R4: With `variant_sel = 0`, a low run shorter than `DEB_A_CYC` samples raises no request.
- R5: With `variant_sel = 1`, a low run of at least `DEB_B_CYC` samples arms the detector. The request comes only on the next low-to-high bus transition, never while the bus stays low.
- R6: With `variant_sel = 1`, a low run shorter than `DEB_B_CYC` samples is discarded. The rise that ends it raises no request.
- R7: A falling edge on the active-low `wake_n` raises a request. Holding the pin low afterwards raises no further request.
- R8: Chip select must be high for at least `CS_FILT_CYC` consecutive samples before the filter accepts it, and acceptance raises a request. A shorter high pulse raises none, and chip select going low raises none.
- R9: If the bus is already low when `arm_en` rises, no request follows until a fresh high-to-low transition is seen after arming.
- R10: After a request, no further request is raised until `arm_en` has been low for at least one cycle and high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | 1 | Asynchronous bus level, 1 = recessive, 0 = dominant |
| wake_n | input | 1 | Asynchronous active-low local wake pin, idles high |
| cs_in | input | 1 | Asynchronous chip select |
| arm_en | input | 1 | Detection enable from the mode controller, high only while powered down |
| variant_sel | input | 1 | 0 = wake after qualified low, 1 = wake on rise after qualified low |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The bench builds the block with `DEB_A_CYC = 5`, `DEB_B_CYC = 12` and `CS_FILT_CYC = 4`. With these values, low runs one sample short of each debounce count and exactly at it, and chip-select pulses one sample short of the filter length and exactly at it, all fit into a few dozen cycles. Every boundary named in the requirements is therefore driven on both sides. A behavioural model in the bench predicts `wake_req` on every clock, and pulse counts per scenario confirm the outcome.

// File: rtl/bwd_pkg.sv
// Shared types for the bus wake-up detector.
// Assumes: nothing beyond a synchronous design.
package bwd_pkg;
    // Bus qualifier states: waiting for a fall, counting a low run, armed for a rise.
    typedef enum logic [1:0] {
        QS_IDLE = 2'd0,
        QS_LOW  = 2'd1,
        QS_QUAL = 2'd2
    } qual_state_t;
endpackage

// File: rtl/bwd_sync.sv
// Two-flop synchronizer for a vector of asynchronous levels.
// Assumes: each bit is an independent slow level; RST_VAL gives idle levels.
module bwd_sync #(
    parameter int          WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    // Two register stages bring the inputs into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/bwd_cs_filter.sv
// Glitch filter for synchronized chip select. The filtered level follows the
// input only after the input has differed from it for FILT_CYC consecutive
// samples. rise_o marks the cycle in which a high level is accepted.
// Assumes: FILT_CYC >= 2; level_i is already synchronized.
module bwd_cs_filter #(
    parameter int FILT_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    localparam int FW = $clog2(FILT_CYC);
    localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);

    logic          filt;
    logic [FW-1:0] run;
    logic          accept;

    // Acceptance happens on the last sample of a full disagreeing run.
    always_comb begin
        accept = (level_i != filt) && (run == LAST);
        rise_o = accept && level_i;
    end

    // Count the disagreeing run and update the filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt <= 1'b0;
            run  <= '0;
        end else if (level_i == filt) begin
            run <= '0;
        end else if (accept) begin
            filt <= level_i;
            run  <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    // A rising filtered level must come from a high input sample.
    assert_cs_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt) |-> $past(level_i))
        else $error("filtered chip select rose without a high input");
endmodule

// File: rtl/bwd_bus_qual.sv
// Bus-level wake qualifier. Counts a low run that starts with a high-to-low
// transition. Variant 0 hits when the run reaches DEB_A_CYC. Variant 1 arms
// at DEB_B_CYC and hits on the next rise. A run that ends early is discarded.
// Assumes: bus_i is synchronized; both debounce counts are >= 2.
module bwd_bus_qual
    import bwd_pkg::*;
#(
    parameter int DEB_A_CYC = 500,
    parameter int DEB_B_CYC = 3500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic var_i,
    input  logic bus_i,
    output logic hit_o
);
    localparam int DEB_MAX = (DEB_A_CYC > DEB_B_CYC) ? DEB_A_CYC : DEB_B_CYC;
    localparam int CW      = $clog2(DEB_MAX + 1);
    localparam logic [CW-1:0] DEB_A_W = CW'(DEB_A_CYC);
    localparam logic [CW-1:0] DEB_B_W = CW'(DEB_B_CYC);

    qual_state_t   st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [CW-1:0] deb;
    logic          bus_prev;

    // Next-state logic for the low-run qualifier.
    always_comb begin
        deb   = var_i ? DEB_B_W : DEB_A_W;
        hit_o = 1'b0;
        st_n  = st;
        cnt_n = cnt;
        if (!arm_i) begin
            st_n  = QS_IDLE;
            cnt_n = '0;
        end else begin
            case (st)
                QS_IDLE: if (bus_prev && !bus_i) begin
                    st_n  = QS_LOW;
                    cnt_n = CW'(1);
                end
                QS_LOW: if (bus_i) begin
                    st_n  = QS_IDLE;
                    cnt_n = '0;
                end else if ((cnt + 1'b1) >= deb) begin
                    cnt_n = '0;
                    if (var_i) begin
                        st_n = QS_QUAL;
                    end else begin
                        hit_o = 1'b1;
                        st_n  = QS_IDLE;
                    end
                end else begin
                    cnt_n = cnt + 1'b1;
                end
                QS_QUAL: if (bus_i) begin
                    hit_o = 1'b1;
                    st_n  = QS_IDLE;
                end
                default: begin
                    st_n  = QS_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // State, run counter and previous bus sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= QS_IDLE;
            cnt      <= '0;
            bus_prev <= 1'b1;
        end else begin
            st       <= st_n;
            cnt      <= cnt_n;
            bus_prev <= bus_i;
        end
    end

    // A hit from the counting state happens with the bus still low.
    assert_level_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == QS_LOW && hit_o) |-> !bus_i)
        else $error("level hit with bus high");

    // A hit from the armed state happens exactly on a low-to-high step.
    assert_rise_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == QS_QUAL && hit_o) |-> (bus_i && !bus_prev))
        else $error("rise hit without a rising bus");

    // The armed state is only held while the bus stays low.
    assert_qual_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == QS_QUAL) |-> !bus_prev)
        else $error("armed state entered from a high bus");
endmodule

// File: rtl/bus_wake_detector.sv
// Top of the bus wake-up detector. Synchronizes the bus, wake pin and chip
// select, qualifies each wake source, and registers a one-cycle request.
// After a request the block holds off until arm_en drops and returns.
// Assumes: arm_en and variant_sel are synchronous to clk.
module bus_wake_detector #(
    parameter int DEB_A_CYC   = 500,
    parameter int DEB_B_CYC   = 3500,
    parameter int CS_FILT_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    input  logic wake_n,
    input  logic cs_in,
    input  logic arm_en,
    input  logic variant_sel,
    output logic wake_req
);
    logic [2:0] sync_q;
    logic       bus_s, wk_s, cs_s;
    logic       wk_prev;
    logic       bus_hit, cs_rise, wk_fall;
    logic       fire;
    logic       fired;

    bwd_sync #(.WIDTH(3), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_in, wake_n, cs_in}),
        .q     (sync_q)
    );

    // Split the synchronized vector into named levels.
    always_comb begin
        bus_s = sync_q[2];
        wk_s  = sync_q[1];
        cs_s  = sync_q[0];
    end

    bwd_bus_qual #(.DEB_A_CYC(DEB_A_CYC), .DEB_B_CYC(DEB_B_CYC)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .arm_i (arm_en),
        .var_i (variant_sel),
        .bus_i (bus_s),
        .hit_o (bus_hit)
    );

    bwd_cs_filter #(.FILT_CYC(CS_FILT_CYC)) u_csf (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (cs_s),
        .rise_o  (cs_rise)
    );

    // Combine the wake sources under the arm and hold-off gates.
    always_comb begin
        wk_fall = wk_prev && !wk_s;
        fire    = arm_en && !fired && (bus_hit || wk_fall || cs_rise);
    end

    // Register the request, the hold-off flag and the previous wake pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_req <= 1'b0;
            fired    <= 1'b0;
            wk_prev  <= 1'b1;
        end else begin
            wake_req <= fire;
            fired    <= arm_en && (fired || fire);
            wk_prev  <= wk_s;
        end
    end

    assert_disarmed_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_en |=> !wake_req)
        else $error("request while disarmed");

    assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req)
        else $error("request wider than one cycle");

    assert_hold_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && arm_en) |=> !wake_req)
        else $error("second request before re-arm");
endmodule

// File: tb/bus_wake_detector_test.sv
module bus_wake_detector_test;
    localparam int DA = 5;
    localparam int DB = 12;
    localparam int CF = 4;

    logic clk = 1'b0;
    logic rst_n, bus_in, wake_n, cs_in, arm_en, variant_sel;
    logic wake_req;

    int n_cmp = 0;
    int n_bad = 0;
    int pulses = 0;
    int run_hi = 0;
    int max_run = 0;
    string cur_req = "R1";
    bit done = 0;

    bus_wake_detector #(.DEB_A_CYC(DA), .DEB_B_CYC(DB), .CS_FILT_CYC(CF)) uut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .wake_n(wake_n),
        .cs_in(cs_in), .arm_en(arm_en), .variant_sel(variant_sel),
        .wake_req(wake_req)
    );

    always #2 clk = ~clk;

    // Behavioural reference: delay lines and run lengths.
    bit bq[2], wq[2], cq[2];
    bit m_bprev, m_wprev, m_cs, m_qual, m_fired, exp_wake;
    int m_low, m_csrun;

    always @(posedge clk) begin
        if (!rst_n) begin
            bq = '{1, 1}; wq = '{1, 1}; cq = '{0, 0};
            m_bprev = 1; m_wprev = 1; m_cs = 0; m_qual = 0; m_fired = 0;
            m_low = 0; m_csrun = 0; exp_wake = 0;
        end else begin
            bit b, w, c, hit, wf, cr, nw;
            int lim;
            b = bq[1]; w = wq[1]; c = cq[1];
            lim = variant_sel ? DB : DA;
            hit = 0;
            if (!arm_en) begin
                m_low = 0; m_qual = 0;
            end else if (m_qual) begin
                if (b) begin hit = 1; m_qual = 0; end
            end else if (m_low > 0) begin
                if (b) m_low = 0;
                else begin
                    m_low++;
                    if (m_low >= lim) begin
                        m_low = 0;
                        if (variant_sel) m_qual = 1; else hit = 1;
                    end
                end
            end else if (m_bprev && !b) begin
                m_low = 1;
            end
            wf = m_wprev && !w;
            cr = 0;
            if (c != m_cs) begin
                m_csrun++;
                if (m_csrun == CF) begin m_cs = c; m_csrun = 0; cr = c; end
            end else m_csrun = 0;
            nw = arm_en && !m_fired && (hit || wf || cr);
            m_fired = arm_en && (m_fired || nw);
            exp_wake = nw;
            m_bprev = b; m_wprev = w;
            bq[1] = bq[0]; bq[0] = bus_in;
            wq[1] = wq[0]; wq[0] = wake_n;
            cq[1] = cq[0]; cq[0] = cs_in;
        end
    end

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        n_cmp++;
        if (wake_req !== exp_wake) begin
            n_bad++;
            $display("FAIL %s: wake_req=%b expected %b at %0t", cur_req, wake_req, exp_wake, $time);
        end
        if (wake_req === 1'b1) begin
            pulses++; run_hi++;
            if (run_hi > max_run) max_run = run_hi;
        end else run_hi = 0;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pulses(input string tag, input int exp);
        n_cmp++;
        if (pulses != exp) begin
            n_bad++;
            $display("FAIL %s: pulses=%0d expected %0d", tag, pulses, exp);
        end
        pulses = 0;
    endtask

    task automatic quiet_rearm(input bit v);
        arm_en = 0; bus_in = 1; wake_n = 1; cs_in = 0; variant_sel = v;
        cyc(10);
        pulses = 0;
        arm_en = 1;
        cyc(4);
    endtask

    task automatic low_run(input int n);
        bus_in = 0; cyc(n); bus_in = 1; cyc(8);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; bus_in = 1; wake_n = 1; cs_in = 0; arm_en = 0; variant_sel = 0;
        cyc(4);
        expect_pulses("R1 reset", 0);
        rst_n = 1;
        cyc(2);

        // R1: activity while disarmed
        cur_req = "R1";
        bus_in = 0; cyc(20); bus_in = 1; cyc(3);
        wake_n = 0; cyc(3); wake_n = 1;
        cs_in = 1; cyc(10); cs_in = 0; cyc(10);
        expect_pulses("R1 disarmed", 0);

        // R3: level variant, run exactly at the count and well past it
        cur_req = "R3";
        quiet_rearm(0); low_run(DA);  expect_pulses("R3 exact", 1);
        quiet_rearm(0); low_run(DA + 6); expect_pulses("R3 long", 1);

        // R4: one sample short, twice
        cur_req = "R4";
        quiet_rearm(0); low_run(DA - 1); low_run(2); expect_pulses("R4 short", 0);

        // R5: rise variant, no request while low, request on rise
        cur_req = "R5";
        quiet_rearm(1);
        bus_in = 0; cyc(DB + 10);
        expect_pulses("R5 still low", 0);
        bus_in = 1; cyc(8);
        expect_pulses("R5 rise", 1);
        quiet_rearm(1); low_run(DB); expect_pulses("R5 exact", 1);

        // R6: short low discarded in rise variant
        cur_req = "R6";
        quiet_rearm(1); low_run(DB - 1); expect_pulses("R6 short", 0);

        // R9: bus already low at arming
        cur_req = "R9";
        arm_en = 0; variant_sel = 0; bus_in = 0; cyc(8); pulses = 0;
        arm_en = 1; cyc(DA + 15);
        expect_pulses("R9 stale low", 0);
        bus_in = 1; cyc(3); low_run(DA + 2);
        expect_pulses("R9 fresh fall", 1);

        // R7: wake pin fall, held low
        cur_req = "R7";
        quiet_rearm(0); wake_n = 0; cyc(15); expect_pulses("R7 wake pin", 1);

        // R8: chip select filter boundary
        cur_req = "R8";
        quiet_rearm(0); cs_in = 1; cyc(CF - 1); cs_in = 0; cyc(10);
        expect_pulses("R8 short", 0);
        quiet_rearm(0); cs_in = 1; cyc(CF); cs_in = 0; cyc(12);
        expect_pulses("R8 exact", 1);

        // R10: hold-off after a request, then re-arm
        cur_req = "R10";
        quiet_rearm(0);
        wake_n = 0; cyc(5);
        low_run(DA + 3);
        cs_in = 1; cyc(CF + 4);
        expect_pulses("R10 hold-off", 1);
        arm_en = 0; wake_n = 1; cyc(6); pulses = 0;
        arm_en = 1; cyc(3); wake_n = 0; cyc(8);
        expect_pulses("R10 re-arm", 1);

        // R2: width of every request seen
        n_cmp++;
        if (max_run != 1) begin
            n_bad++;
            $display("FAIL R2: widest request=%0d expected 1", max_run);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule